// File: doc/BRIEF.md
# Load/Store Byte-Lane Aligner

This block sits between a 32-bit integer core and a memory that is addressed by whole 32-bit words. It has two channels that work on their own, side by side.

The store channel takes the access width code, the two low address bits and the register value to be written. It returns the write word with the byte or halfword copied into every lane it could occupy, plus a four-bit lane-enable mask. Only the mask picks the lane that the memory updates.

The load channel takes the width code, the two low address bits and the word the memory returned. It picks out the byte, halfword or word at the given offset and widens it to 32 bits, with sign or zero fill set by the code. Lanes are in little-endian order: lane k holds bits 8k+7 down to 8k.

Each channel has a one-cycle register stage. Accesses that are not aligned, and width codes that are not defined, raise a flag and nothing else. Trapping, address generation and the memory itself belong to other blocks.

Top module: `lsu_lane_align`

## Requirements
- R1: While rst_n is low, every output is zero.
- R2: Each output shows the inputs sampled at the previous rising clock edge. In a cycle where a channel's valid input was low, that channel's outputs are all zero.
- R3: The store enable mask is computed from st_funct3 and the offset. Code 000 (byte) gives 0001 shifted left by the offset. Code 001 (halfword) gives 0011 shifted left by the offset. Code 010 (word) gives 1111.
- R4: Store data copies the value into lanes. A byte store puts st_value[7:0] in all four lanes. A halfword store puts st_value[15:0] in both halves. A word store passes st_value unchanged.
- R5: A halfword store at an odd offset, or a word store at a nonzero offset, sets st_misaligned and forces wr_be to 0000.
- R6: A store code of 011 or higher sets st_illegal and forces both wr_be and wr_data to zero.
- R7: A byte load takes lane `offset` of ld_word. Code 000 sign-extends it and code 100 zero-extends it.
- R8: A halfword load takes bits 16*offset[1]+15 down to 16*offset[1] of ld_word. Code 001 sign-extends it and code 101 zero-extends it.
- R9: A word load (code 010) at offset 0 returns ld_word unchanged.
- R10: A halfword load at an odd offset, or a word load at a nonzero offset, sets ld_misaligned and returns zero.
- R11: A load code of 011, 110 or 111 sets ld_illegal and returns zero.
- R12: Store a byte at some offset, merge it into a memory word under the enable mask, then load it back as a byte from the same offset. The result is the same byte, sign-extended for code 000 and zero-extended for code 100.
- R13: The two channels do not affect each other. A store and a load in the same cycle each give the result they would give alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| st_valid | input | 1 | Store request present |
| st_funct3 | input | 3 | Store width code |
| st_offset | input | 2 | Low address bits of the store |
| st_value | input | 32 | Register value to store |
| ld_valid | input | 1 | Load request present |
| ld_funct3 | input | 3 | Load width and sign code |
| ld_offset | input | 2 | Low address bits of the load |
| ld_word | input | 32 | Word returned by memory |
| wr_data | output | 32 | Store data copied into lanes |
| wr_be | output | 4 | Store lane enables |
| st_misaligned | output | 1 | Store not aligned to its width |
| st_illegal | output | 1 | Store width code not defined |
| ld_result | output | 32 | Widened load result |
| ld_misaligned | output | 1 | Load not aligned to its width |
| ld_illegal | output | 1 | Load width code not defined |

## Verification
A store and a load can fall in the same cycle. The bench provokes this by walking every store code and offset while, in the same cycles, it drives a load whose code and offset are rotated through all values.

The reference model computes both channels' results from their own inputs alone. Every output is compared on every clock, so a mix-up between the channels shows as a mismatch on the other channel's fields.

A store-then-reload sequence goes through a bench memory word updated under the enable mask. It tests the two paths against each other.

// File: rtl/lsu_lane_align.sv
module lsu_lane_align (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        st_valid,
  input  logic [2:0]  st_funct3,
  input  logic [1:0]  st_offset,
  input  logic [31:0] st_value,
  input  logic        ld_valid,
  input  logic [2:0]  ld_funct3,
  input  logic [1:0]  ld_offset,
  input  logic [31:0] ld_word,
  output logic [31:0] wr_data,
  output logic [3:0]  wr_be,
  output logic        st_misaligned,
  output logic        st_illegal,
  output logic [31:0] ld_result,
  output logic        ld_misaligned,
  output logic        ld_illegal
);

  localparam logic [2:0] W_BYTE  = 3'b000;
  localparam logic [2:0] W_HALF  = 3'b001;
  localparam logic [2:0] W_WORD  = 3'b010;
  localparam logic [2:0] W_BYTEU = 3'b100;
  localparam logic [2:0] W_HALFU = 3'b101;

  logic        st_b, st_h, st_w, st_bad, st_mis;
  logic [3:0]  st_mask, st_be_n;
  logic [31:0] st_data_n;

  assign st_b   = st_funct3 == W_BYTE;
  assign st_h   = st_funct3 == W_HALF;
  assign st_w   = st_funct3 == W_WORD;
  assign st_bad = st_valid && !(st_b || st_h || st_w);
  assign st_mis = st_valid && ((st_h && st_offset[0]) || (st_w && st_offset != 2'd0));

  assign st_mask = st_b ? (4'b0001 << st_offset) :
                   st_h ? (4'b0011 << st_offset) :
                   st_w ? 4'b1111 : 4'b0000;

  assign st_be_n = (st_valid && !st_bad && !st_mis) ? st_mask : 4'b0000;

  assign st_data_n = (!st_valid || st_bad) ? 32'd0 :
                     st_b ? {4{st_value[7:0]}} :
                     st_h ? {2{st_value[15:0]}} : st_value;

  logic        ld_b, ld_h, ld_w, ld_sgn, ld_bad, ld_mis;
  logic [31:0] ld_shift, ld_res_n;

  assign ld_b   = ld_funct3 == W_BYTE || ld_funct3 == W_BYTEU;
  assign ld_h   = ld_funct3 == W_HALF || ld_funct3 == W_HALFU;
  assign ld_w   = ld_funct3 == W_WORD;
  assign ld_sgn = !ld_funct3[2];
  assign ld_bad = ld_valid && !(ld_b || ld_h || ld_w);
  assign ld_mis = ld_valid && ((ld_h && ld_offset[0]) || (ld_w && ld_offset != 2'd0));

  assign ld_shift = ld_word >> {ld_offset, 3'b000};

  always_comb begin
    ld_res_n = 32'd0;
    if (ld_valid && !ld_bad && !ld_mis) begin
      if (ld_b)
        ld_res_n = {{24{ld_sgn & ld_shift[7]}}, ld_shift[7:0]};
      else if (ld_h)
        ld_res_n = {{16{ld_sgn & ld_shift[15]}}, ld_shift[15:0]};
      else
        ld_res_n = ld_word;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_data       <= 32'd0;
      wr_be         <= 4'd0;
      st_misaligned <= 1'b0;
      st_illegal    <= 1'b0;
      ld_result     <= 32'd0;
      ld_misaligned <= 1'b0;
      ld_illegal    <= 1'b0;
    end else begin
      wr_data       <= st_data_n;
      wr_be         <= st_be_n;
      st_misaligned <= st_mis;
      st_illegal    <= st_bad;
      ld_result     <= ld_res_n;
      ld_misaligned <= ld_mis;
      ld_illegal    <= ld_bad;
    end
  end

endmodule

module lsu_lane_align_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        st_valid,
  input logic        ld_valid,
  input logic [31:0] wr_data,
  input logic [3:0]  wr_be,
  input logic        st_misaligned,
  input logic        st_illegal,
  input logic [31:0] ld_result,
  input logic        ld_misaligned,
  input logic        ld_illegal
);

  AST_ST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !st_valid |=> (wr_be == 4'd0 && wr_data == 32'd0 && !st_misaligned && !st_illegal)); // R2

  AST_LD_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_valid |=> (ld_result == 32'd0 && !ld_misaligned && !ld_illegal)); // R2

  AST_BE_HALF_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(wr_be) == 2) |-> (wr_be == 4'b0011 || wr_be == 4'b1100)); // R3

  AST_BE_NO_THREE: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(wr_be) != 3); // R3

  AST_BYTE_REPLICA: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(wr_be) == 1) |-> (wr_data[7:0] == wr_data[31:24] && wr_data[15:8] == wr_data[23:16])); // R4

  AST_ST_MIS_NO_BE: assert property (@(posedge clk) disable iff (!rst_n)
    st_misaligned |-> (wr_be == 4'd0 && !st_illegal)); // R5

  AST_ST_ILL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    st_illegal |-> (wr_be == 4'd0 && wr_data == 32'd0)); // R6

  AST_LD_MIS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ld_misaligned |-> (ld_result == 32'd0 && !ld_illegal)); // R10

  AST_LD_ILL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ld_illegal |-> ld_result == 32'd0); // R11

endmodule

bind lsu_lane_align lsu_lane_align_chk u_chk (
  .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .ld_valid(ld_valid),
  .wr_data(wr_data), .wr_be(wr_be), .st_misaligned(st_misaligned),
  .st_illegal(st_illegal), .ld_result(ld_result),
  .ld_misaligned(ld_misaligned), .ld_illegal(ld_illegal)
);

// File: tb/test_lsu_lane_align.sv
module test_lsu_lane_align;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        st_valid = 1'b0;
  logic [2:0]  st_funct3 = 3'd0;
  logic [1:0]  st_offset = 2'd0;
  logic [31:0] st_value = 32'd0;
  logic        ld_valid = 1'b0;
  logic [2:0]  ld_funct3 = 3'd0;
  logic [1:0]  ld_offset = 2'd0;
  logic [31:0] ld_word = 32'd0;
  logic [31:0] wr_data, ld_result;
  logic [3:0]  wr_be;
  logic        st_misaligned, st_illegal, ld_misaligned, ld_illegal;

  lsu_lane_align i_lsu_lane_align (
    .clk(clk), .rst_n(rst_n),
    .st_valid(st_valid), .st_funct3(st_funct3), .st_offset(st_offset), .st_value(st_value),
    .ld_valid(ld_valid), .ld_funct3(ld_funct3), .ld_offset(ld_offset), .ld_word(ld_word),
    .wr_data(wr_data), .wr_be(wr_be), .st_misaligned(st_misaligned), .st_illegal(st_illegal),
    .ld_result(ld_result), .ld_misaligned(ld_misaligned), .ld_illegal(ld_illegal)
  );

  always #4 clk = ~clk;

  int total = 0;
  int failed = 0;
  bit done = 0;

  logic [31:0] e_wd, e_lr;
  logic [3:0]  e_be;
  logic        e_sm, e_si, e_lm, e_li;
  string       t_st, t_ld;
  bit          pending = 0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      failed++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic void ref_store(bit v, logic [2:0] f, logic [1:0] o, logic [31:0] d,
      output logic [3:0] be, output logic [31:0] wd, output logic mis, output logic ill,
      output string tag);
    int size;
    be = 0; wd = 0; mis = 0; ill = 0; tag = "R2";
    if (!v) return;
    case (f)
      3'd0: size = 1;
      3'd1: size = 2;
      3'd2: size = 4;
      default: size = 0;
    endcase
    if (size == 0) begin ill = 1; tag = "R6"; return; end
    for (int i = 0; i < 4; i++)
      for (int b = 0; b < 8; b++) wd[8*i+b] = d[8*(i % size)+b];
    if ((int'(o) % size) != 0) begin mis = 1; tag = "R5"; return; end
    for (int i = 0; i < size; i++) be[int'(o)+i] = 1'b1;
    tag = "R3";
  endfunction

  function automatic void ref_load(bit v, logic [2:0] f, logic [1:0] o, logic [31:0] w,
      output logic [31:0] r, output logic mis, output logic ill, output string tag);
    int size;
    bit sgn;
    r = 0; mis = 0; ill = 0; tag = "R2";
    if (!v) return;
    sgn = (f[2] == 1'b0);
    case (f)
      3'd0, 3'd4: begin size = 1; tag = "R7"; end
      3'd1, 3'd5: begin size = 2; tag = "R8"; end
      3'd2:       begin size = 4; tag = "R9"; end
      default:    begin size = 0; tag = "R11"; end
    endcase
    if (size == 0) begin ill = 1; return; end
    if ((int'(o) % size) != 0) begin mis = 1; tag = "R10"; return; end
    for (int b = 0; b < 32; b++)
      if (b < 8*size) r[b] = w[8*int'(o)+b];
      else r[b] = sgn ? w[8*int'(o)+8*size-1] : 1'b0;
  endfunction

  task automatic step(bit sv, logic [2:0] sf, logic [1:0] so, logic [31:0] sd,
                      bit lv, logic [2:0] lf, logic [1:0] lo, logic [31:0] lw);
    @(negedge clk);
    if (pending) begin
      chk({t_st, " wr_be"}, {28'd0, wr_be}, {28'd0, e_be});
      chk({(t_st == "R3") ? "R4" : t_st, " wr_data"}, wr_data, e_wd);
      chk({t_st, " st_misaligned"}, {31'd0, st_misaligned}, {31'd0, e_sm});
      chk({t_st, " st_illegal"}, {31'd0, st_illegal}, {31'd0, e_si});
      chk({t_ld, " ld_result"}, ld_result, e_lr);
      chk({t_ld, " ld_misaligned"}, {31'd0, ld_misaligned}, {31'd0, e_lm});
      chk({t_ld, " ld_illegal"}, {31'd0, ld_illegal}, {31'd0, e_li});
    end
    st_valid = sv; st_funct3 = sf; st_offset = so; st_value = sd;
    ld_valid = lv; ld_funct3 = lf; ld_offset = lo; ld_word = lw;
    ref_store(sv, sf, so, sd, e_be, e_wd, e_sm, e_si, t_st);
    ref_load(lv, lf, lo, lw, e_lr, e_lm, e_li, t_ld);
    pending = 1;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      total++; failed++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", total - failed, total);
      $finish;
    end
  end

  initial begin
    logic [31:0] mem;
    logic [7:0]  v;
    repeat (3) @(negedge clk);
    chk("R1 wr_data", wr_data, 32'd0);
    chk("R1 wr_be", {28'd0, wr_be}, 32'd0);
    chk("R1 ld_result", ld_result, 32'd0);
    chk("R1 flags", {28'd0, st_misaligned, st_illegal, ld_misaligned, ld_illegal}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;

    step(0, 3'd2, 2'd0, 32'hFFFF_FFFF, 0, 3'd2, 2'd0, 32'hFFFF_FFFF);

    for (int f = 0; f < 8; f++)
      for (int o = 0; o < 4; o++)
        step(1, 3'(f), 2'(o), 32'h8A5C_F3E1 ^ 32'(f * 16 + o),
             1, 3'((f + o) % 8), 2'(o + f), 32'hC39A_817F);

    for (int f = 0; f < 8; f++)
      for (int o = 0; o < 4; o++) begin
        step(0, 3'd0, 2'd0, 32'd0, 1, 3'(f), 2'(o), 32'h7F80_01FE);
        step(1, 3'(f), 2'(o), 32'h0000_80FF, 0, 3'd0, 2'd0, 32'd0);
      end

    for (int n = 0; n < 400; n++)
      step(1'($urandom), 3'($urandom), 2'($urandom), $urandom,
           1'($urandom), 3'($urandom), 2'($urandom), $urandom);

    mem = 32'h1234_5678;
    for (int o = 0; o < 4; o++)
      for (int s = 0; s < 2; s++) begin
        v = (s == 0) ? 8'h9C : 8'h4D;
        step(1, 3'd0, 2'(o), {24'hABCDEF, v}, 0, 3'd0, 2'd0, 32'd0);
        step(0, 3'd0, 2'd0, 32'd0, 0, 3'd0, 2'd0, 32'd0);
        for (int i = 0; i < 4; i++)
          if (wr_be[i]) mem[8*i +: 8] = wr_data[8*i +: 8];
        step(0, 3'd0, 2'd0, 32'd0, 1, 3'd0, 2'(o), mem);
        step(0, 3'd0, 2'd0, 32'd0, 1, 3'd4, 2'(o), mem);
        chk("R12 signed reload", ld_result, {{24{v[7]}}, v});
        step(0, 3'd0, 2'd0, 32'd0, 0, 3'd0, 2'd0, 32'd0);
        chk("R12 unsigned reload", ld_result, {24'd0, v});
      end

    step(1, 3'd1, 2'd2, 32'h0000_BEEF, 1, 3'd5, 2'd2, 32'hBEEF_0000);
    step(0, 3'd0, 2'd0, 32'd0, 0, 3'd0, 2'd0, 32'd0);
    chk("R13 concurrent", {wr_be, ld_result[27:0]}, {4'b1100, 28'h000BEEF});
    step(0, 3'd0, 2'd0, 32'd0, 0, 3'd0, 2'd0, 32'd0);

    done = 1;
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end

endmodule